// File: doc/BRIEF.md
# Debounced Quadrature Position Counter

This block keeps a signed 32-bit position count driven by two count inputs and one marker input, all three coming from mechanical or industrial sources. Each input first crosses into the system clock domain and then passes a stability filter whose length is a power of two. The block accepts a new level only when that level has held for the whole filter window.

The filtered count pair is decoded in one of four selectable ways: a Gray-coded two-phase encoder, a plain 2-bit binary code, a count pulse with a separate direction level, or separate up and down pulse inputs. The marker input either forces the count to zero or is reported as a push-button press. Two signed limit values can wrap the count, zero it, or only raise a flag when a step would carry the count past a limit.

Every count step is also sent out as a one-cycle strobe with a direction bit, so that a neighbouring timer can measure the interval between steps. Sticky flags record events until they are cleared one bit at a time, and an interrupt line is the OR of all the flags.

Top module: `updown_pos_counter`

## Requirements
- R1: After reset, count is 0, flags is 0, cnt_evt is 0 and irq is 0.
- R2: A filtered input takes a new level only after the synchronised raw level has differed from the current filtered level for 2^cfg_db_exp consecutive clocks. A shorter pulse has no effect on the count.
- R3: With cfg_dec=0, the pair {in_a,in_b} is read as Gray phases. Each step along 00,01,11,10,00 adds 1 and each step the opposite way subtracts 1, which gives four counts per full cycle.
- R4: With cfg_dec=0, a change of both bits at once leaves the count unchanged and sets flags bit 0. With cfg_dec=1, a change of 2 in the code does the same.
- R5: With cfg_dec=1, {in_a,in_b} is a binary number with in_a as the MSB. A change of +1 modulo 4 adds 1 and a change of -1 modulo 4 subtracts 1.
- R6: With cfg_dec=2, each rising edge of in_a counts once. The step is up when in_b is 1 and down when in_b is 0. Falling edges and in_b changes do not count.
- R7: With cfg_dec=3, a rising edge of in_a adds 1 and a rising edge of in_b subtracts 1. When both rise in the same cycle, the count does not change.
- R8: A rising edge of the filtered in_z sets flags bit 1. When cfg_zm_clear=1, that edge also clears the count, and this overrides any step in the same cycle.
- R9: With cfg_bnd=0 (or 3), the count steps freely. An up step whose result exceeds cfg_upper sets flags bit 2. A down step whose result is below cfg_lower sets flags bit 3.
- R10: With cfg_bnd=1, an up step past cfg_upper loads cfg_lower and a down step past cfg_lower loads cfg_upper. Flags bit 2 or bit 3 is set as in R9.
- R11: With cfg_bnd=2, a step past either limit loads 0 and sets flags bit 2 or bit 3 as in R9.
- R12: Each decoded step produces exactly one single-cycle cnt_evt pulse, in the cycle in which the count takes the stepped value. cnt_dir is 1 for an up step and 0 for a down step.
- R13: Flags stay set until the matching flag_clr bit is high for a cycle; a new set in that same cycle wins. irq is high exactly when any flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_a | input | 1 | Raw count input A (phase, MSB, pulse or up) |
| in_b | input | 1 | Raw count input B (phase, LSB, direction or down) |
| in_z | input | 1 | Raw zero-marker / push-button input |
| cfg_dec | input | 2 | Decode selection, see R3 to R7 |
| cfg_db_exp | input | 4 | Filter window exponent: 2^cfg_db_exp clocks |
| cfg_zm_clear | input | 1 | 1: marker clears the count |
| cfg_bnd | input | 2 | Limit behaviour, see R9 to R11 |
| cfg_upper | input | 32 | Signed upper limit |
| cfg_lower | input | 32 | Signed lower limit |
| flag_clr | input | 4 | Per-bit flag clear |
| count | output | 32 | Signed position count |
| cnt_evt | output | 1 | One-cycle step strobe |
| cnt_dir | output | 1 | Direction of the last step, 1 = up |
| flags | output | 4 | Sticky flags: 0 decode error, 1 marker, 2 upper, 3 lower |
| irq | output | 1 | OR of all flags |

## Verification
The Gray decoder is driven forwards around a full cycle, then backwards across zero into negative counts, and then with a two-bit jump; together these separate correct direction sensing, sign handling and illegal-step rejection. In binary mode the bench applies increments, decrements across the 3-to-0 wrap and a jump of two, which tells modulo arithmetic apart from Gray-style decoding. In pulse-and-direction mode it applies rising and falling edges and lone direction changes, so that the decoder is shown to count rising edges only. In the separate-edge mode it applies single rises, a swap in which one input rises while the other falls, and a simultaneous rise, which shows that edges are detected rather than levels. A glitch shorter than the filter window and a pulse longer than it show whether the filter length is honoured.

// File: rtl/ud_pkg.sv
package ud_pkg;

  typedef enum logic [1:0] {
    DEC_GRAY     = 2'd0,
    DEC_BINARY   = 2'd1,
    DEC_DIRPULSE = 2'd2,
    DEC_EDGES    = 2'd3
  } dec_mode_e;

  typedef enum logic [1:0] {
    BND_LIMIT = 2'd0,
    BND_WRAP  = 2'd1,
    BND_ZERO  = 2'd2,
    BND_RSVD  = 2'd3
  } bnd_mode_e;

  typedef struct packed {
    logic up;
    logic dn;
    logic err;
  } step_t;

  localparam int FLG_ERR = 0;
  localparam int FLG_ZM  = 1;
  localparam int FLG_UP  = 2;
  localparam int FLG_LO  = 3;
  localparam int NFLAGS  = 4;

  // Pair is {a,b}; forward order 00 -> 01 -> 11 -> 10 -> 00
  function automatic step_t gray_step(logic [1:0] p, logic [1:0] c);
    step_t s;
    logic [1:0] fwd;
    s = '0;
    unique case (p)
      2'b00:   fwd = 2'b01;
      2'b01:   fwd = 2'b11;
      2'b11:   fwd = 2'b10;
      default: fwd = 2'b00;
    endcase
    if (p != c) begin
      if (c == fwd)     s.up  = 1'b1;
      else if (&(p ^ c)) s.err = 1'b1;
      else              s.dn  = 1'b1;
    end
    return s;
  endfunction

  function automatic step_t binary_step(logic [1:0] p, logic [1:0] c);
    step_t s;
    logic [1:0] d;
    s = '0;
    d = c - p;
    s.up  = (d == 2'd1);
    s.dn  = (d == 2'd3);
    s.err = (d == 2'd2);
    return s;
  endfunction

  function automatic step_t dirpulse_step(logic [1:0] p, logic [1:0] c);
    step_t s;
    logic rise;
    s = '0;
    rise = c[1] & ~p[1];
    s.up = rise & c[0];
    s.dn = rise & ~c[0];
    return s;
  endfunction

  function automatic step_t edges_step(logic [1:0] p, logic [1:0] c);
    step_t s;
    logic ra, rb;
    s = '0;
    ra = c[1] & ~p[1];
    rb = c[0] & ~p[0];
    s.up = ra & ~rb;
    s.dn = rb & ~ra;
    return s;
  endfunction

endpackage

// File: rtl/ud_debounce.sv
module ud_debounce #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw,
  input  logic [EXP_W-1:0] exp_n,
  output logic             level
);
  localparam int RUN_W = 1 << EXP_W;

  logic [1:0]       sync;
  logic [RUN_W-1:0] run;
  logic [RUN_W-1:0] run_last;
  logic             at_last;

  assign run_last = (RUN_W'(1) << exp_n) - RUN_W'(1);
  assign at_last  = (run == run_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync  <= '0;
      run   <= '0;
      level <= 1'b0;
    end else begin
      sync <= {sync[0], raw};
      if (sync[1] == level) begin
        run <= '0;
      end else if (at_last) begin
        level <= sync[1];
        run   <= '0;
      end else begin
        run <= run + RUN_W'(1);
      end
    end
  end
endmodule

// File: rtl/ud_decode.sv
module ud_decode
  import ud_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic [1:0] pair,
  output logic       ev_up,
  output logic       ev_dn,
  output logic       ev_err
);
  logic [1:0] prev;
  step_t      st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= pair;
  end

  always_comb begin
    unique case (dec_mode_e'(mode))
      DEC_GRAY:     st = gray_step(prev, pair);
      DEC_BINARY:   st = binary_step(prev, pair);
      DEC_DIRPULSE: st = dirpulse_step(prev, pair);
      default:      st = edges_step(prev, pair);
    endcase
  end

  assign ev_up  = st.up;
  assign ev_dn  = st.dn;
  assign ev_err = st.err;
endmodule

// File: rtl/ud_bound.sv
module ud_bound
  import ud_pkg::*;
#(
  parameter int W = 32
) (
  input  logic signed [W-1:0] cur,
  input  logic                up,
  input  logic                dn,
  input  logic [1:0]          mode,
  input  logic signed [W-1:0] upper,
  input  logic signed [W-1:0] lower,
  output logic signed [W-1:0] nxt,
  output logic                hit_up,
  output logic                hit_lo
);
  logic signed [W-1:0] stepped;

  always_comb begin
    if (up)      stepped = cur + W'(1);
    else if (dn) stepped = cur - W'(1);
    else         stepped = cur;
    hit_up = up && (stepped > upper);
    hit_lo = dn && (stepped < lower);
    unique case (bnd_mode_e'(mode))
      BND_WRAP:
        nxt = hit_up ? lower : (hit_lo ? upper : stepped);
      BND_ZERO:
        nxt = (hit_up || hit_lo) ? '0 : stepped;
      default:
        nxt = stepped;
    endcase
  end
endmodule

// File: rtl/updown_pos_counter.sv
module updown_pos_counter
  import ud_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int DB_EXP_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_a,
  input  logic                    in_b,
  input  logic                    in_z,
  input  logic [1:0]              cfg_dec,
  input  logic [DB_EXP_W-1:0]     cfg_db_exp,
  input  logic                    cfg_zm_clear,
  input  logic [1:0]              cfg_bnd,
  input  logic signed [CNT_W-1:0] cfg_upper,
  input  logic signed [CNT_W-1:0] cfg_lower,
  input  logic [NFLAGS-1:0]       flag_clr,
  output logic signed [CNT_W-1:0] count,
  output logic                    cnt_evt,
  output logic                    cnt_dir,
  output logic [NFLAGS-1:0]       flags,
  output logic                    irq
);
  localparam int NPINS = 3;

  logic [NPINS-1:0]    raw_vec;
  logic [NPINS-1:0]    deb_vec;
  logic                z_prev;
  logic                z_rise;
  logic                ev_up, ev_dn, ev_err;
  logic                hit_up, hit_lo;
  logic signed [CNT_W-1:0] nxt;
  logic [NFLAGS-1:0]   set_vec;

  assign raw_vec = {in_z, in_b, in_a};

  for (genvar g = 0; g < NPINS; g++) begin : g_deb
    ud_debounce #(.EXP_W(DB_EXP_W)) u_deb (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (raw_vec[g]),
      .exp_n (cfg_db_exp),
      .level (deb_vec[g])
    );
  end

  ud_decode u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (cfg_dec),
    .pair   ({deb_vec[0], deb_vec[1]}),
    .ev_up  (ev_up),
    .ev_dn  (ev_dn),
    .ev_err (ev_err)
  );

  ud_bound #(.W(CNT_W)) u_bnd (
    .cur    (count),
    .up     (ev_up),
    .dn     (ev_dn),
    .mode   (cfg_bnd),
    .upper  (cfg_upper),
    .lower  (cfg_lower),
    .nxt    (nxt),
    .hit_up (hit_up),
    .hit_lo (hit_lo)
  );

  assign z_rise = deb_vec[2] & ~z_prev;

  always_comb begin
    set_vec          = '0;
    set_vec[FLG_ERR] = ev_err;
    set_vec[FLG_ZM]  = z_rise;
    set_vec[FLG_UP]  = hit_up;
    set_vec[FLG_LO]  = hit_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      cnt_evt <= 1'b0;
      cnt_dir <= 1'b0;
      z_prev  <= 1'b0;
      flags   <= '0;
    end else begin
      z_prev  <= deb_vec[2];
      cnt_evt <= ev_up | ev_dn;
      if (ev_up | ev_dn) cnt_dir <= ev_up;
      if (z_rise && cfg_zm_clear) count <= '0;
      else                        count <= nxt;
      flags <= (flags & ~flag_clr) | set_vec;
    end
  end

  assign irq = |flags;
endmodule

// File: rtl/ud_checker.sv
module ud_checker #(
  parameter int W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic signed [W-1:0] count,
  input logic signed [W-1:0] upper,
  input logic signed [W-1:0] lower,
  input logic [1:0]          bnd,
  input logic                zm_clear,
  input logic                ev_up,
  input logic                ev_dn,
  input logic                ev_err,
  input logic                z_rise,
  input logic                cnt_evt,
  input logic                cnt_dir,
  input logic [3:0]          flags,
  input logic [3:0]          flag_clr
);
  logic signed [W-1:0] inc;
  assign inc = count + W'(1);

  assert_one_direction_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_up && ev_dn));

  assert_strobe_follows_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_up || ev_dn) |=> (cnt_evt && (cnt_dir == $past(ev_up))));

  assert_quiet_holds_count_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_up && !ev_dn && !z_rise) |=> $stable(count));

  assert_decode_error_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> flags[0]);

  assert_marker_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (z_rise && zm_clear) |=> (count == '0));

  assert_free_up_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_up && !z_rise && bnd == 2'd0) |=> (count == $past(inc)));

  assert_wrap_to_lower_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_up && !z_rise && bnd == 2'd1 && inc > upper) |=> (count == $past(lower)));

  assert_flags_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flags) & ~$past(flag_clr)) & ~flags) == 4'd0));
endmodule

bind updown_pos_counter ud_checker #(.W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .count    (count),
  .upper    (cfg_upper),
  .lower    (cfg_lower),
  .bnd      (cfg_bnd),
  .zm_clear (cfg_zm_clear),
  .ev_up    (ev_up),
  .ev_dn    (ev_dn),
  .ev_err   (ev_err),
  .z_rise   (z_rise),
  .cnt_evt  (cnt_evt),
  .cnt_dir  (cnt_dir),
  .flags    (flags),
  .flag_clr (flag_clr)
);

// File: tb/test_updown_pos_counter.sv
`timescale 1ns/1ps
module test_updown_pos_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_a = 0, in_b = 0, in_z = 0;
  logic [1:0] cfg_dec = 2'd0;
  logic [3:0] cfg_db_exp = 4'd1;
  logic cfg_zm_clear = 1'b0;
  logic [1:0] cfg_bnd = 2'd0;
  logic signed [31:0] cfg_upper = 32'sd1000;
  logic signed [31:0] cfg_lower = -32'sd1000;
  logic [3:0] flag_clr = 4'd0;
  logic signed [31:0] count;
  logic cnt_evt, cnt_dir, irq;
  logic [3:0] flags;

  int n_chk = 0;
  int n_bad = 0;
  int n_evt = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  updown_pos_counter i_updown_pos_counter (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .in_z(in_z),
    .cfg_dec(cfg_dec), .cfg_db_exp(cfg_db_exp), .cfg_zm_clear(cfg_zm_clear),
    .cfg_bnd(cfg_bnd), .cfg_upper(cfg_upper), .cfg_lower(cfg_lower),
    .flag_clr(flag_clr), .count(count), .cnt_evt(cnt_evt), .cnt_dir(cnt_dir),
    .flags(flags), .irq(irq)
  );

  always @(negedge clk) if (rst_n && cnt_evt) n_evt++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp=<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_a(input int n);
    in_a = 1'b1; settle(n);
    in_a = 1'b0; settle(n);
  endtask

  task automatic clear_all();
    flag_clr = 4'hF; settle(1);
    flag_clr = 4'h0; settle(1);
  endtask

  // {dec[1:0], a, b, count[7:0], err}; count is sign-extended
  localparam int NV = 28;
  localparam logic [12:0] VEC [NV] = '{
    {2'd0,1'b0,1'b1,8'd1,1'b0},  {2'd0,1'b1,1'b1,8'd2,1'b0},
    {2'd0,1'b1,1'b0,8'd3,1'b0},  {2'd0,1'b0,1'b0,8'd4,1'b0},
    {2'd0,1'b1,1'b0,8'd3,1'b0},  {2'd0,1'b1,1'b1,8'd2,1'b0},
    {2'd0,1'b0,1'b1,8'd1,1'b0},  {2'd0,1'b0,1'b0,8'd0,1'b0},
    {2'd0,1'b1,1'b0,8'hFF,1'b0}, {2'd0,1'b0,1'b1,8'hFF,1'b1},
    {2'd1,1'b0,1'b1,8'hFF,1'b1}, {2'd1,1'b1,1'b0,8'd0,1'b1},
    {2'd1,1'b1,1'b1,8'd1,1'b1},  {2'd1,1'b0,1'b0,8'd2,1'b1},
    {2'd1,1'b1,1'b1,8'd1,1'b1},  {2'd1,1'b0,1'b1,8'd1,1'b1},
    {2'd2,1'b1,1'b1,8'd2,1'b1},  {2'd2,1'b0,1'b1,8'd2,1'b1},
    {2'd2,1'b0,1'b0,8'd2,1'b1},  {2'd2,1'b1,1'b0,8'd1,1'b1},
    {2'd2,1'b0,1'b0,8'd1,1'b1},  {2'd3,1'b1,1'b0,8'd2,1'b1},
    {2'd3,1'b0,1'b0,8'd2,1'b1},  {2'd3,1'b0,1'b1,8'd1,1'b1},
    {2'd3,1'b1,1'b0,8'd2,1'b1},  {2'd3,1'b0,1'b1,8'd1,1'b1},
    {2'd3,1'b0,1'b0,8'd1,1'b1},  {2'd3,1'b1,1'b1,8'd1,1'b1}
  };

  initial begin
    settle(3);
    // R1: reset state
    check(count == 0 && flags == 0 && !cnt_evt && !irq, "R1 reset", {flags, 27'd0, cnt_evt}, 32'd0);
    rst_n = 1'b1;
    settle(4);

    // R3 R4 R5 R6 R7: vector walk with 2-clock filter
    for (int i = 0; i < NV; i++) begin
      logic [12:0] v;
      logic [31:0] e;
      v = VEC[i];
      cfg_dec = v[12:11]; in_a = v[10]; in_b = v[9];
      settle(12);
      e = {{24{v[8]}}, v[8:1]};
      check(count == e && flags[0] == v[0],
            (v[12:11] == 0) ? "R3/R4 gray" : (v[12:11] == 1) ? "R5/R4 binary" :
            (v[12:11] == 2) ? "R6 dirpulse" : "R7 edges",
            {count[30:0], flags[0]}, {e[30:0], v[0]});
    end
    // R12: one strobe per step in the walk
    check(n_evt == 19, "R12 strobe total", n_evt, 32'd19);
    check(flags == 4'b0001 && irq, "R13 sticky err", {27'd0, irq, flags}, 32'h11);
    clear_all();
    check(flags == 0 && !irq, "R13 clear", {27'd0, irq, flags}, 32'd0);

    // R2: filter window of 16 clocks
    cfg_db_exp = 4'd4; cfg_dec = 2'd2; in_a = 0; in_b = 1;
    settle(40);
    in_a = 1; settle(8); in_a = 0; settle(40);
    check(count == 1, "R2 glitch ignored", count, 32'd1);
    pulse_a(40);
    check(count == 2, "R2 long pulse counts", count, 32'd2);
    check(cnt_dir == 1'b1, "R12 dir up", cnt_dir, 32'd1);
    cfg_db_exp = 4'd1; settle(4);

    // R8: marker as button, then as clear
    cfg_zm_clear = 0; in_z = 1; settle(12); in_z = 0; settle(12);
    check(count == 2 && flags == 4'b0010, "R8 button", {count[27:0], flags}, {28'd2, 4'b0010});
    clear_all();
    cfg_zm_clear = 1; in_z = 1; settle(12); in_z = 0; settle(12);
    check(count == 0 && flags == 4'b0010, "R8 clear", {count[27:0], flags}, {28'd0, 4'b0010});
    clear_all();

    // R9: limit flags only
    cfg_bnd = 2'd0; cfg_upper = 2; cfg_lower = -2; in_b = 1;
    pulse_a(12); pulse_a(12);
    check(count == 2 && flags == 0, "R9 at limit", {count[27:0], flags}, {28'd2, 4'd0});
    pulse_a(12);
    check(count == 3 && flags == 4'b0100, "R9 past upper", {count[27:0], flags}, {28'd3, 4'b0100});
    clear_all();

    // R10: wrap
    cfg_bnd = 2'd1; cfg_upper = 4;
    pulse_a(12);
    check(count == 4 && flags == 0, "R10 reach upper", {count[27:0], flags}, {28'd4, 4'd0});
    pulse_a(12);
    check(count == -2 && flags == 4'b0100, "R10 wrap to lower", {count[27:0], flags}, {28'hFFFFFFE, 4'b0100});
    clear_all();
    in_b = 0; settle(12);
    pulse_a(12);
    check(count == 4 && flags == 4'b1000, "R10 wrap to upper", {count[27:0], flags}, {28'd4, 4'b1000});
    check(cnt_dir == 1'b0, "R12 dir down", cnt_dir, 32'd0);
    clear_all();

    // R11: zero on crossing
    cfg_bnd = 2'd2; in_b = 1; settle(12);
    pulse_a(12);
    check(count == 0 && flags == 4'b0100 && irq, "R11 zero on upper", {count[26:0], irq, flags}, 32'h14);
    clear_all();
    check(!irq, "R13 irq low", irq, 32'd0);
    check(n_evt == 27, "R12 strobe total", n_evt, 32'd27);

    // R1: reset mid-run
    pulse_a(12);
    check(count == 1, "R11 step inside", count, 32'd1);
    rst_n = 0; settle(2);
    check(count == 0 && flags == 0 && !cnt_evt, "R1 reset again", count, 32'd0);
    rst_n = 1; settle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule